// File: doc/BRIEF.md
# Frame Sync Loss Detector

This block watches the frame sync strobe of a time-division multiplexed serial link and raises a lost-synchronisation flag when the framing stops making sense. It runs on the link bit clock and counts clock cycles from one sync rising edge to the next. At each sync edge it judges the frame just completed. A frame is correct when its length matches the programmed length, or that length plus one clock of slack. In double-clock mode the count must also be even. At the two high line rates the number of bits carried must also fit the rate's granularity. A sync that does not appear within the slack window counts as missing.

The flag is sticky, and setting it produces a one-cycle interrupt pulse. The host clears the flag with a one-cycle clear strobe. After a reset or a clear, the detector hunts: it ignores faults until it has seen two correct frames in a row, and only then can it set the flag again. The first sync after reset, or after a missing-sync timeout, only serves as a timing reference.

Top module: `lsync_detector`

## Requirements
- R1: After reset, `lsync_o` and `irq_o` are 0.
- R2: Once armed, frames whose clock count equals `frame_len_i` or `frame_len_i`+1 leave `lsync_o` at 0, provided the format checks below pass.
- R3: Once armed, a sync edge that arrives fewer than `frame_len_i` clocks after the previous one sets `lsync_o`.
- R4: Once armed, if no sync edge arrives within `frame_len_i`+1 clocks of the previous edge, `lsync_o` is set one clock after the count passes `frame_len_i`+1 (on the clock edge that ends the cycle in which the count equals `frame_len_i`+2 counting the reference edge as 1).
- R5: With `dbl_clk_i`=1, an odd clock count in a frame sets `lsync_o`. With `dbl_clk_i`=0, odd counts cause no fault at `rate_i`=00.
- R6: With `rate_i`=10 or 11 (8 Mb/s), a bit count per frame that is not a multiple of 4 sets `lsync_o`.
- R7: With `rate_i`=01 (4 Mb/s), an odd bit count per frame sets `lsync_o`. The bit count is the clock count, halved when `dbl_clk_i`=1. `rate_i`=00 applies no granularity check.
- R8: `lsync_o` stays at 1 through later correct frames until `clr_i` is high on a clock edge. After that edge it reads 0.
- R9: After reset or clear, faults do not set `lsync_o` until two consecutive correct frames have been judged. The first sync after reset or after a timeout is a reference only.
- R10: `irq_o` is high for exactly the one cycle in which `lsync_o` first becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync_i | input | 1 | Frame sync strobe; its rising edge starts a frame |
| dbl_clk_i | input | 1 | 1 = two clocks per bit |
| rate_i | input | 2 | 00 no granularity check, 01 4 Mb/s, 10/11 8 Mb/s |
| frame_len_i | input | CNT_W | Expected clocks per frame |
| clr_i | input | 1 | Host clear of the flag; also restarts hunting |
| lsync_o | output | 1 | Sticky lost-synchronisation flag |
| irq_o | output | 1 | One-cycle pulse when the flag sets |

## Verification
A fault is judged combinationally in the cycle where the sync edge is sampled. `lsync_o` and `irq_o` therefore change on the next clock edge, and the bench samples them at the following falling edge, inside its pulse task. A missing sync is flagged on the edge after the counter passes `frame_len_i`+1. The bench counts falling edges from the reference sync and checks 0 one cycle before that edge and 1 just after it. A frame's verdict appears only at the next sync edge, so every faulty gap is followed by one more pulse before the check. The one exception is a programmed length change, which is applied just after an edge so that it governs only the frame being timed.

// File: rtl/lsd_pkg.sv
`timescale 1ns/1ps
package lsd_pkg;
   typedef enum logic [1:0] {
      LSD_RATE_BASE  = 2'b00,
      LSD_RATE_4M    = 2'b01,
      LSD_RATE_8M    = 2'b10,
      LSD_RATE_SPARE = 2'b11
   } lsd_rate_e;
endpackage

// File: rtl/lsd_frame_timer.sv
`timescale 1ns/1ps
// Sync edge detection, per-frame clock counter and missing-sync timeout.
module lsd_frame_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync_i,
   input  logic [CNT_W-1:0] frame_len_i,
   output logic             sync_edge_o,
   output logic [CNT_W-1:0] len_o,
   output logic             ref_o,
   output logic             timeout_o
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             fs_q;
   logic [CNT_W-1:0] cnt_q;
   logic             ref_q;

   assign sync_edge_o = fsync_i & ~fs_q;
   assign len_o       = cnt_q;
   assign ref_o       = ref_q;
   // count has run past length plus one clock of slack with no edge
   assign timeout_o   = ref_q & ~sync_edge_o & (cnt_q > frame_len_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fs_q  <= 1'b0;
         cnt_q <= '0;
         ref_q <= 1'b0;
      end else begin
         fs_q <= fsync_i;
         if (sync_edge_o)
            cnt_q <= CNT_ONE;
         else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + CNT_ONE;
         if (sync_edge_o)
            ref_q <= 1'b1;
         else if (timeout_o)
            ref_q <= 1'b0;
      end
   end
endmodule

// File: rtl/lsd_frame_check.sv
`timescale 1ns/1ps
// Judges a finished frame: arrival window, clock parity, bit granularity.
module lsd_frame_check
   import lsd_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter bit SPARE_IS_8M = 1'b1
) (
   input  logic             dbl_clk_i,
   input  lsd_rate_e        rate_i,
   input  logic [CNT_W-1:0] len_i,
   input  logic [CNT_W-1:0] frame_len_i,
   output logic             good_o
);
   logic [CNT_W:0]   len_x;
   logic [CNT_W:0]   lim_x;
   logic [CNT_W-1:0] bits;
   logic             time_ok;
   logic             odd_bad;
   logic             gran_bad;

   assign len_x   = {1'b0, len_i};
   assign lim_x   = {1'b0, frame_len_i};
   assign time_ok = (len_x == lim_x) || (len_x == lim_x + (CNT_W+1)'(1));
   assign odd_bad = dbl_clk_i & len_i[0];
   assign bits    = dbl_clk_i ? {1'b0, len_i[CNT_W-1:1]} : len_i;

   generate
      if (SPARE_IS_8M) begin : g_spare_8m
         always_comb begin
            if (rate_i[1])                 gran_bad = |bits[1:0];
            else if (rate_i == LSD_RATE_4M) gran_bad = bits[0];
            else                           gran_bad = 1'b0;
         end
      end else begin : g_spare_off
         always_comb begin
            case (rate_i)
               LSD_RATE_4M: gran_bad = bits[0];
               LSD_RATE_8M: gran_bad = |bits[1:0];
               default:     gran_bad = 1'b0;
            endcase
         end
      end
   endgenerate

   assign good_o = time_ok & ~odd_bad & ~gran_bad;
endmodule

// File: rtl/lsd_lsync_ctrl.sv
`timescale 1ns/1ps
// Hunting / armed control, sticky flag and set pulse.
module lsd_lsync_ctrl #(
   parameter int REARM_FRAMES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic frame_done_i,
   input  logic frame_good_i,
   input  logic timeout_i,
   output logic armed_o,
   output logic lsync_o,
   output logic irq_o
);
   localparam int GW = $clog2(REARM_FRAMES + 1);
   localparam logic [GW-1:0] GOOD_LAST = GW'(REARM_FRAMES - 1);

   logic [GW-1:0] good_q;
   logic          armed_q;
   logic          lsync_q;
   logic          irq_q;
   logic          bad_evt;
   logic          fault;

   assign bad_evt = timeout_i | (frame_done_i & ~frame_good_i);
   assign fault   = armed_q & bad_evt;
   assign armed_o = armed_q;
   assign lsync_o = lsync_q;
   assign irq_o   = irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         good_q  <= '0;
         armed_q <= 1'b0;
         lsync_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         irq_q   <= fault & ~lsync_q;
         lsync_q <= lsync_q | fault;
         if (!armed_q) begin
            if (bad_evt)
               good_q <= '0;
            else if (frame_done_i) begin
               if (good_q == GOOD_LAST) begin
                  armed_q <= 1'b1;
                  good_q  <= '0;
               end else
                  good_q <= good_q + GW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/lsync_detector.sv
`timescale 1ns/1ps
module lsync_detector
   import lsd_pkg::*;
#(
   parameter int CNT_W        = 12,
   parameter int REARM_FRAMES = 2,
   parameter bit SPARE_IS_8M  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync_i,
   input  logic             dbl_clk_i,
   input  logic [1:0]       rate_i,
   input  logic [CNT_W-1:0] frame_len_i,
   input  logic             clr_i,
   output logic             lsync_o,
   output logic             irq_o
);
   generate
      if (CNT_W < 3) begin : g_bad_cnt_w
         $error("lsync_detector: CNT_W must be at least 3");
      end
      if (REARM_FRAMES < 1) begin : g_bad_rearm
         $error("lsync_detector: REARM_FRAMES must be at least 1");
      end
   endgenerate

   logic             sync_edge;
   logic [CNT_W-1:0] frame_cnt;
   logic             ref_ok;
   logic             timeout;
   logic             frame_good;
   logic             armed_w;

   lsd_frame_timer #(.CNT_W(CNT_W)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .fsync_i     (fsync_i),
      .frame_len_i (frame_len_i),
      .sync_edge_o (sync_edge),
      .len_o       (frame_cnt),
      .ref_o       (ref_ok),
      .timeout_o   (timeout)
   );

   lsd_frame_check #(.CNT_W(CNT_W), .SPARE_IS_8M(SPARE_IS_8M)) u_check (
      .dbl_clk_i   (dbl_clk_i),
      .rate_i      (lsd_rate_e'(rate_i)),
      .len_i       (frame_cnt),
      .frame_len_i (frame_len_i),
      .good_o      (frame_good)
   );

   lsd_lsync_ctrl #(.REARM_FRAMES(REARM_FRAMES)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_i        (clr_i),
      .frame_done_i (sync_edge & ref_ok),
      .frame_good_i (frame_good),
      .timeout_i    (timeout),
      .armed_o      (armed_w),
      .lsync_o      (lsync_o),
      .irq_o        (irq_o)
   );
endmodule

// File: rtl/lsync_detector_chk.sv
`timescale 1ns/1ps
module lsync_detector_chk (
   input logic clk,
   input logic rst_n,
   input logic clr_i,
   input logic armed,
   input logic lsync_o,
   input logic irq_o
);
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!lsync_o && !irq_o));

   p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lsync_o && !clr_i) |=> lsync_o);

   p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (!lsync_o && !irq_o));

   p_irq_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (lsync_o && !$past(lsync_o)));

   p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   p_set_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lsync_o) |-> $past(armed));
endmodule

bind lsync_detector lsync_detector_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .clr_i   (clr_i),
   .armed   (armed_w),
   .lsync_o (lsync_o),
   .irq_o   (irq_o)
);

// File: tb/lsync_detector_test.sv
`timescale 1ns/1ps
module lsync_detector_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        fsync;
   logic        dbl;
   logic [1:0]  rate;
   logic [11:0] flen;
   logic        clr;
   logic        lsync;
   logic        irq;
   logic        last_irq;
   int          n_chk = 0;
   int          n_bad = 0;

   always #10 clk = ~clk;

   lsync_detector uut (
      .clk(clk), .rst_n(rst_n), .fsync_i(fsync), .dbl_clk_i(dbl),
      .rate_i(rate), .frame_len_i(flen), .clr_i(clr),
      .lsync_o(lsync), .irq_o(irq)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic d, input logic [1:0] r, input int len);
      rst_n = 1'b0; fsync = 1'b0; clr = 1'b0;
      dbl = d; rate = r; flen = 12'(len);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // sync high one cycle, next edge comes gap cycles later; new length applied just after the edge
   task automatic pulse(input int gap, input int new_len);
      @(negedge clk) fsync = 1'b1;
      @(negedge clk) fsync = 1'b0;
      last_irq = irq;
      flen = 12'(new_len);
      repeat (gap - 2) @(negedge clk);
   endtask

   task automatic arm(input int len);
      for (int i = 0; i < 3; i++) pulse(len, len);
   endtask

   task automatic t_reset;
      rst_n = 1'b0; fsync = 1'b0; clr = 1'b0; dbl = 1'b0; rate = 2'b00; flen = 12'd16;
      repeat (2) @(negedge clk);
      chk("R1 lsync after reset", lsync, 1'b0);
      chk("R1 irq after reset", irq, 1'b0);
      rst_n = 1'b1;
   endtask

   task automatic t_steady;
      do_reset(1'b0, 2'b00, 16);
      arm(16);
      pulse(16, 16); pulse(17, 16); pulse(16, 16); pulse(17, 16); pulse(16, 16);
      chk("R2 lengths L and L+1 accepted", lsync, 1'b0);
      chk("R2 no irq", last_irq, 1'b0);
   endtask

   task automatic t_early;
      do_reset(1'b0, 2'b00, 16);
      arm(16);
      pulse(12, 16); pulse(16, 16);
      chk("R3 early sync sets flag", lsync, 1'b1);
      chk("R10 irq pulse on set", last_irq, 1'b1);
      @(negedge clk);
      chk("R10 irq lasts one cycle", irq, 1'b0);
   endtask

   task automatic t_missing;
      do_reset(1'b0, 2'b00, 16);
      arm(16);
      repeat (2) @(negedge clk);
      chk("R4 not flagged while count within slack", lsync, 1'b0);
      @(negedge clk);
      chk("R4 missing sync sets flag", lsync, 1'b1);
      chk("R10 irq on timeout set", irq, 1'b1);
   endtask

   task automatic t_double;
      do_reset(1'b1, 2'b00, 18);
      arm(18);
      chk("R5 even counts accepted in double clock", lsync, 1'b0);
      pulse(19, 18); pulse(18, 18);
      chk("R5 odd count in double clock sets flag", lsync, 1'b1);
      do_reset(1'b0, 2'b00, 18);
      arm(18);
      pulse(19, 18); pulse(18, 18);
      chk("R5 odd count ignored in single clock", lsync, 1'b0);
   endtask

   task automatic t_rate8;
      do_reset(1'b0, 2'b10, 32);
      arm(32);
      pulse(34, 34); pulse(34, 34);
      chk("R6 8 Mb/s 34 bits sets flag", lsync, 1'b1);
      do_reset(1'b0, 2'b11, 32);
      arm(32);
      pulse(34, 34); pulse(34, 34);
      chk("R6 code 11 acts as 8 Mb/s", lsync, 1'b1);
      do_reset(1'b1, 2'b10, 64);
      arm(64);
      chk("R6 8 Mb/s double clock 32 bits accepted", lsync, 1'b0);
   endtask

   task automatic t_rate4;
      do_reset(1'b0, 2'b01, 32);
      arm(32);
      pulse(34, 34); pulse(34, 34);
      chk("R7 4 Mb/s 34 bits accepted", lsync, 1'b0);
      pulse(35, 34); pulse(34, 34);
      chk("R7 4 Mb/s odd bit count sets flag", lsync, 1'b1);
      do_reset(1'b1, 2'b01, 36);
      arm(36);
      pulse(34, 34); pulse(34, 34);
      chk("R7 double clock 17 bits sets flag", lsync, 1'b1);
      do_reset(1'b0, 2'b00, 32);
      arm(32);
      pulse(34, 34); pulse(35, 34); pulse(34, 34);
      chk("R7 base rate has no granularity check", lsync, 1'b0);
   endtask

   task automatic t_sticky_hunt;
      do_reset(1'b0, 2'b00, 16);
      arm(16);
      pulse(12, 16); pulse(16, 16); pulse(16, 16); pulse(16, 16);
      chk("R8 flag stays set over good frames", lsync, 1'b1);
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
      chk("R8 clear drops flag", lsync, 1'b0);
      // timeout during hunting cleared the reference: next sync is reference only
      pulse(12, 16); pulse(16, 16);
      chk("R9 fault while hunting ignored", lsync, 1'b0);
      chk("R9 no irq while hunting", last_irq, 1'b0);
      pulse(16, 16); pulse(12, 16); pulse(16, 16);
      chk("R9 re-armed after two good frames", lsync, 1'b1);
      do_reset(1'b0, 2'b00, 16);
      pulse(16, 16); pulse(12, 16); pulse(16, 16);
      chk("R9 one good frame does not arm", lsync, 1'b0);
   endtask

   initial begin
      last_irq = 1'b0;
      t_reset();
      t_steady();
      t_early();
      t_missing();
      t_double();
      t_rate8();
      t_rate4();
      t_sticky_hunt();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #3_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule